// File: doc/BRIEF.md
# Numeric Error Reporting Controller

This block sits in a processor core between the floating-point unit and instruction issue. It decides how a pending, unmasked floating-point error is reported. A mode bit chooses between two schemes. In native mode the core raises an internal exception-16 request. In legacy mode the block drives an active-low error pin to external interrupt logic, and it holds instruction issue until software has dealt with the error.

The decode stage gives the block a strobe for the next instruction. The strobe carries three flags: floating-point instruction, WAIT instruction, and non-waiting control instruction. Clear-exceptions and initialize are examples of non-waiting control instructions. Only floating-point and WAIT instructions are "waiting" instructions, and only they can fault or stall.

In legacy mode, an external ignore-error pin lets the handler run floating-point code while the error pin is still asserted. The error pin goes high again once software clears the error inside the FPU.

Top module: `numerr_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, `err_out_n` is 1, `issue_stall` is 0 and `mf_req` is 0, provided `fpu_err_pend` is 0.
- R2: With `ne_mode`=1 and `fpu_err_pend`=1, `mf_req` is 1 in the same cycle that a valid floating-point or WAIT instruction is presented. In native mode `err_out_n` stays 1 and `issue_stall` stays 0, whatever the level of `ign_err_n`.
- R3: In native mode a pending error alone does not raise `mf_req`. It stays 0 while no valid instruction is presented, and while the presented instruction is neither floating-point nor WAIT.
- R4: With `ne_mode`=0, `err_out_n` is 0 in the cycle after a clock edge that samples `fpu_err_pend`=1. `mf_req` is never 1 in legacy mode.
- R5: With `ne_mode`=0, `fpu_err_pend`=1 and `ign_err_n`=1, `issue_stall` is 1 while a valid floating-point or WAIT instruction is presented.
- R6: While `ign_err_n`=0 (active low), `issue_stall` is 0, and `err_out_n` stays 0 as long as the legacy error is pending.
- R7: `err_out_n` returns to 1 in the cycle after a clock edge that samples `fpu_err_pend`=0.
- R8: An instruction flagged non-waiting control never causes `issue_stall` or `mf_req`. This holds even when its floating-point or WAIT flag is also set; the non-waiting flag takes priority.
- R9: `issue_stall` falls in the same cycle, with no clock edge in between, that `fpu_err_pend` falls or `ign_err_n` goes to 0.
- R10: When `dec_valid` is 0, the three instruction flags have no effect: `mf_req` and `issue_stall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fpu_err_pend | input | 1 | FPU holds a pending unmasked error |
| ne_mode | input | 1 | 1 selects native exception reporting, 0 selects legacy pin reporting |
| ign_err_n | input | 1 | Ignore-error pin, active low |
| dec_valid | input | 1 | Decode strobe for the next instruction |
| dec_is_fp | input | 1 | Presented instruction is floating-point |
| dec_is_wait | input | 1 | Presented instruction is WAIT |
| dec_is_nowait | input | 1 | Presented instruction is a non-waiting control instruction |
| mf_req | output | 1 | Internal exception-16 request |
| err_out_n | output | 1 | External error pin, active low |
| issue_stall | output | 1 | Freezes instruction issue |

## Verification
The assertions check three things on every cycle:
- the error pin follows the legacy pending error with one cycle of lag;
- no exception request appears in legacy mode;
- the stall never coexists with an active ignore-error pin, a non-waiting instruction or native mode.

Other behaviour can only be shown by the bench's scenarios: the same-cycle release of the stall when the pending error drops or the ignore pin asserts, the deferral of the native request until a waiting instruction arrives, and mode switches while an error is pending.

// File: rtl/numerr_pkg.sv
// Package: shared types for the numeric error reporting controller.
// Assumes: the decode stage presents at most one instruction per cycle.
package numerr_pkg;
    // Classification of the instruction presented by decode.
    typedef enum logic [1:0] {
        CLS_NONE    = 2'd0,   // no instruction, or one unrelated to the FPU
        CLS_WAITING = 2'd1,   // floating-point or WAIT: checks pending errors
        CLS_NOWAIT  = 2'd2    // non-waiting control: bypasses error checks
    } insn_cls_e;
endpackage

// File: rtl/numerr_decode.sv
// Module: sorts the decode strobe into one instruction class.
// Assumes: the flags are only meaningful while dec_valid is high. The
// non-waiting flag overrides the floating-point and WAIT flags.
module numerr_decode
    import numerr_pkg::*;
(
    input  logic      dec_valid,
    input  logic      dec_is_fp,
    input  logic      dec_is_wait,
    input  logic      dec_is_nowait,
    output insn_cls_e cls
);
    // Priority classification: invalid, then non-waiting, then waiting.
    always_comb begin
        if (!dec_valid)
            cls = CLS_NONE;
        else if (dec_is_nowait)
            cls = CLS_NOWAIT;
        else if (dec_is_fp || dec_is_wait)
            cls = CLS_WAITING;
        else
            cls = CLS_NONE;
    end
endmodule

// File: rtl/numerr_native.sv
// Module: native reporting path, which raises the exception-16 request.
// Assumes: the request is raised when a waiting instruction is presented
// while an error is pending, not when the error occurs. It repeats on
// every such instruction until the error is cleared.
module numerr_native
    import numerr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ne_mode,
    input  logic      fpu_err_pend,
    input  insn_cls_e cls,
    output logic      mf_req
);
    // Fault request: native mode, pending error, waiting instruction.
    always_comb begin
        mf_req = ne_mode && fpu_err_pend && (cls == CLS_WAITING);
    end

    // R4: the native request stays silent while legacy mode is selected.
    a_r4_no_fault_in_legacy: assert property (@(posedge clk) disable iff (!rst_n)
        !ne_mode |-> !mf_req);

    // R8: non-waiting control instructions never fault.
    a_r8_nowait_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_NOWAIT) |-> !mf_req);
endmodule

// File: rtl/numerr_legacy.sv
// Module: legacy reporting path, made of the external error pin and the
// issue freeze.
// Assumes: ign_err_n is already synchronous to clk. The freeze is built
// from live inputs so that it releases in the cycle its cause goes away.
// PIN_REGISTERED selects a flopped pin (default) or a direct one.
module numerr_legacy
    import numerr_pkg::*;
#(
    parameter bit PIN_REGISTERED = 1'b1
)(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ne_mode,
    input  logic      fpu_err_pend,
    input  logic      ign_err_n,
    input  insn_cls_e cls,
    output logic      err_out_n,
    output logic      issue_stall
);
    logic legacy_err;

    // Error visible through the external path only in legacy mode.
    always_comb begin
        legacy_err = !ne_mode && fpu_err_pend;
    end

    generate
        if (PIN_REGISTERED) begin : g_pin_reg
            logic err_q;

            // Flop the pin level so the pad sees a clean registered edge.
            always_ff @(posedge clk) begin
                if (!rst_n) err_q <= 1'b0;
                else        err_q <= legacy_err;
            end

            assign err_out_n = !err_q;

            // R4: the pin asserts one cycle after a legacy error is sampled.
            a_r4_pin_asserts: assert property (@(posedge clk) disable iff (!rst_n)
                legacy_err |=> !err_out_n);

            // R7: the pin releases one cycle after the error is cleared.
            a_r7_pin_releases: assert property (@(posedge clk) disable iff (!rst_n)
                !fpu_err_pend |=> err_out_n);
        end else begin : g_pin_comb
            assign err_out_n = !legacy_err;
        end
    endgenerate

    // Freeze issue on a waiting instruction unless ignore-error is active.
    always_comb begin
        issue_stall = legacy_err && ign_err_n && (cls == CLS_WAITING);
    end

    // R6: an active ignore-error pin never coexists with a freeze.
    a_r6_ignore_unfreezes: assert property (@(posedge clk) disable iff (!rst_n)
        !ign_err_n |-> !issue_stall);

    // R5: a freeze is only ever raised for a waiting instruction.
    a_r5_stall_on_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stall |-> (cls == CLS_WAITING));
endmodule

// File: rtl/numerr_ctrl.sv
// Module: top of the numeric error reporting controller. It classifies the
// decoded instruction and runs the native and legacy reporting paths side
// by side; ne_mode decides which path can act.
// Assumes: fpu_err_pend stays high until software clears the error inside
// the FPU.
module numerr_ctrl
    import numerr_pkg::*;
#(
    parameter bit PIN_REGISTERED = 1'b1
)(
    input  logic clk,
    input  logic rst_n,
    input  logic fpu_err_pend,
    input  logic ne_mode,
    input  logic ign_err_n,
    input  logic dec_valid,
    input  logic dec_is_fp,
    input  logic dec_is_wait,
    input  logic dec_is_nowait,
    output logic mf_req,
    output logic err_out_n,
    output logic issue_stall
);
    insn_cls_e cls;

    numerr_decode u_decode (
        .dec_valid     (dec_valid),
        .dec_is_fp     (dec_is_fp),
        .dec_is_wait   (dec_is_wait),
        .dec_is_nowait (dec_is_nowait),
        .cls           (cls)
    );

    numerr_native u_native (
        .clk          (clk),
        .rst_n        (rst_n),
        .ne_mode      (ne_mode),
        .fpu_err_pend (fpu_err_pend),
        .cls          (cls),
        .mf_req       (mf_req)
    );

    numerr_legacy #(
        .PIN_REGISTERED (PIN_REGISTERED)
    ) u_legacy (
        .clk          (clk),
        .rst_n        (rst_n),
        .ne_mode      (ne_mode),
        .fpu_err_pend (fpu_err_pend),
        .ign_err_n    (ign_err_n),
        .cls          (cls),
        .err_out_n    (err_out_n),
        .issue_stall  (issue_stall)
    );

    // R2: native mode never freezes issue.
    a_r2_native_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ne_mode |-> !issue_stall);

    // R8: a non-waiting instruction at the ports never freezes issue.
    a_r8_nowait_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_is_nowait) |-> !issue_stall);

    // R10: without a valid strobe, neither a fault nor a freeze appears.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!issue_stall && !mf_req));
endmodule

// File: tb/numerr_ctrl_bench.sv
`timescale 1ns/1ps
module numerr_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n;
    logic fpu_err_pend, ne_mode, ign_err_n;
    logic dec_valid, dec_is_fp, dec_is_wait, dec_is_nowait;
    logic mf_req, err_out_n, issue_stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    numerr_ctrl u_numerr_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .fpu_err_pend  (fpu_err_pend),
        .ne_mode       (ne_mode),
        .ign_err_n     (ign_err_n),
        .dec_valid     (dec_valid),
        .dec_is_fp     (dec_is_fp),
        .dec_is_wait   (dec_is_wait),
        .dec_is_nowait (dec_is_nowait),
        .mf_req        (mf_req),
        .err_out_n     (err_out_n),
        .issue_stall   (issue_stall)
    );

    // Vector layout: {ne, pend, ign_n, valid, fp, wait, nowait, exp_mf, exp_stall}
    localparam int NV = 14;
    localparam logic [8:0] VEC [NV] = '{
        9'b1_1_1_1_1_0_0_1_0,   // R2 fp faults
        9'b1_1_1_1_0_1_0_1_0,   // R2 wait faults
        9'b1_1_1_0_1_0_0_0_0,   // R10 invalid strobe
        9'b1_1_1_1_0_0_0_0_0,   // R3 non-fp instruction
        9'b1_0_1_1_1_0_0_0_0,   // no error pending
        9'b1_1_1_1_0_0_1_0_0,   // R8 nowait in native
        9'b0_1_1_1_1_0_0_0_1,   // R5 fp freezes
        9'b0_1_1_1_0_1_0_0_1,   // R5 wait freezes
        9'b0_1_0_1_1_0_0_0_0,   // R6 ignore active
        9'b0_1_1_1_1_0_1_0_0,   // R8 nowait priority
        9'b0_1_1_0_1_0_0_0_0,   // R10 invalid strobe
        9'b0_0_1_1_1_0_0_0_0,   // no error pending
        9'b0_1_1_1_0_0_0_0_0,   // non-fp instruction
        9'b1_1_0_1_1_0_0_1_0    // R2 ignore pin has no effect in native
    };

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] v);
        {ne_mode, fpu_err_pend, ign_err_n, dec_valid,
         dec_is_fp, dec_is_wait, dec_is_nowait} = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(7'b1_0_1_0_0_0_0);
        repeat (3) @(posedge clk);
        #1;
        check("R1", "err_out_n in reset", err_out_n, 1'b1);
        check("R1", "issue_stall in reset", issue_stall, 1'b0);
        check("R1", "mf_req in reset", mf_req, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", "err_out_n after reset", err_out_n, 1'b1);

        // Table walk: drive at the falling edge, sample just after the next
        // rising edge, once the pin flop has taken the new inputs.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][8:2]);
            @(posedge clk); #1;
            check("R2", $sformatf("mf_req vec %0d", i), mf_req, VEC[i][1]);
            check("R5", $sformatf("issue_stall vec %0d", i), issue_stall, VEC[i][0]);
            check("R4", $sformatf("err_out_n vec %0d", i), err_out_n,
                  !(!VEC[i][8] && VEC[i][7]));
        end

        // R9/R7: the freeze drops without a clock edge when the error clears;
        // the pin follows at the next edge.
        @(negedge clk);
        drive(7'b0_1_1_1_1_0_0);
        @(posedge clk); #1;
        check("R5", "freeze set", issue_stall, 1'b1);
        fpu_err_pend = 1'b0; #0.5;
        check("R9", "freeze drops same cycle on clear", issue_stall, 1'b0);
        check("R7", "pin still low before edge", err_out_n, 1'b0);
        @(posedge clk); #1;
        check("R7", "pin released after clear", err_out_n, 1'b1);

        // R9/R6: the freeze drops at once when ignore-error asserts; the pin
        // stays low.
        @(negedge clk);
        drive(7'b0_1_1_1_0_1_0);
        @(posedge clk); #1;
        check("R5", "freeze set on wait", issue_stall, 1'b1);
        ign_err_n = 1'b0; #0.5;
        check("R9", "freeze drops same cycle on ignore", issue_stall, 1'b0);
        @(posedge clk); #1;
        check("R6", "pin held during ignore", err_out_n, 1'b0);
        check("R6", "no freeze during ignore", issue_stall, 1'b0);

        // R4: a mode switch to native releases the pin and faults instead.
        @(negedge clk);
        drive(7'b1_1_1_1_1_0_0);
        @(posedge clk); #1;
        check("R4", "pin released in native", err_out_n, 1'b1);
        check("R2", "fault after switch to native", mf_req, 1'b1);

        // R3: no fault while idle, then a fault once an fp instruction arrives.
        @(negedge clk);
        drive(7'b1_1_1_0_0_0_0);
        @(posedge clk); #1;
        check("R3", "idle with pending error", mf_req, 1'b0);
        dec_valid = 1'b1; dec_is_fp = 1'b1; #0.5;
        check("R2", "fault on fp decode", mf_req, 1'b1);

        // R8: an initialize-type instruction in legacy mode passes and leaves
        // the pin low.
        @(negedge clk);
        drive(7'b0_1_1_1_0_1_1);
        @(posedge clk); #1;
        check("R8", "nowait with wait flag", issue_stall, 1'b0);
        check("R4", "no fault in legacy", mf_req, 1'b0);

        // R1: reset reapplied returns the pin high.
        @(negedge clk);
        rst_n = 1'b0;
        fpu_err_pend = 1'b0;
        @(posedge clk); #1;
        check("R1", "pin high on re-reset", err_out_n, 1'b1);

        finish_run();
    end
endmodule